// File: doc/BRIEF.md
# Routable Interrupt Source Collector

This block gathers a set of interrupt request lines (32 by default), holds each one in a pending latch, and steers every pending source whose enable is set onto one of several CPU interrupt lines. The destination of each source is chosen by a small route field stored next to that source's enable bit. Eight sources share each 32-bit control word, so four control words cover all sources.

Software reaches the block over a plain register bus with full-word reads and writes. It programs a source by reading its control word, changing that source's 4-bit field, and writing the word back. It reads the pending state of every source from one status word. It retires events by writing ones to a clear register. A source that is still held high is latched again straight away, so level requests are not lost.

Top module: `irq_router_top`

## Requirements
- R1: After reset every control word, every pending bit and every output line is zero.
- R2: A bus write to byte address 0x00 + 4*w (w = 0..3) loads control word w whole. A read at that address returns it, and the other control words do not change. Source n's field sits in word n/8 at bits (n mod 8)*4 +: 4. In that field bit 3 is the enable and bits 2:0 are the route.
- R3: A source that is high at a rising clock edge sets its pending bit from that edge. Pending bits are read as one word at address 0x10, with bit n holding source n.
- R4: A pending bit stays set after its source goes low, until software clears it.
- R5: A write to address 0x14 clears each pending bit whose position in the write data is one. Bits written with zero keep their state. A read of 0x14 returns zero.
- R6: If a source is high in the same cycle as a clear of its bit, the bit stays pending.
- R7: Output line k (k in 0..4 or 6) is high exactly when at least one source is pending, enabled and routed to k. It follows the state with no extra register.
- R8: Route values 5 and 7 drive no line. irq_line[5] and irq_line[7] are always low.
- R9: A pending source with its enable at zero drives no line, but its status bit still reads one.
- R10: A write to the status address has no effect on the state. A read of any address outside 0x00 to 0x14 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Interrupt source lines, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_line | output | 8 | CPU interrupt lines, indexed by route value |

## Verification
A wrong pending latch shows at the status word and on the routed line one edge after the stimulus. A stuck bit survives a clear and a lost bit drops before any clear. A wrong bit in a control word shows at once as a line asserted on the wrong index, or a line that is missing for a pending source. A word read back that differs from what was written also shows it. Any disturbance of a neighbour's field during a write shows when that neighbouring word is read back in the same test.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int FIELD_W    = 4;
   localparam int ROUTE_W    = 3;
   localparam int EN_BIT     = 3;
   localparam int N_LINES    = 1 << ROUTE_W;
   localparam int A_CTRL0    = 'h00;
   localparam int A_STATUS   = 'h10;
   localparam int A_CLEAR    = 'h14;
   localparam logic [N_LINES-1:0] LEGAL_ROUTES = 8'b0101_1111;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [N_SRC*FIELD_W-1:0]   ctrl_flat
);
   localparam int N_WORDS = N_SRC * FIELD_W / DATA_W;

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr && addr == ADDR_W'(A_CTRL0 + 4 * w))
            word_q <= wdata;
      end
      assign ctrl_flat[w*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic             clr_we,
   input  logic [N_SRC-1:0] clr_mask,
   output logic [N_SRC-1:0] pend
);
   logic [N_SRC-1:0] kill;

   assign kill = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= '0;
      else
         pend <= (pend & ~kill) | src;
   end
endmodule

// File: rtl/irq_route_or.sv
module irq_route_or
   import irq_router_pkg::*;
#(
   parameter int N_SRC = 32
) (
   input  logic [N_SRC-1:0]          pend,
   input  logic [N_SRC*FIELD_W-1:0]  ctrl_flat,
   output logic [N_LINES-1:0]        line
);
   logic [N_SRC-1:0] live;

   always_comb begin
      for (int s = 0; s < N_SRC; s++)
         live[s] = pend[s] & ctrl_flat[s*FIELD_W + EN_BIT];
   end

   for (genvar k = 0; k < N_LINES; k++) begin : g_line
      if (LEGAL_ROUTES[k]) begin : g_used
         logic hit;
         always_comb begin
            hit = 1'b0;
            for (int s = 0; s < N_SRC; s++)
               if (live[s] && ctrl_flat[s*FIELD_W +: ROUTE_W] == ROUTE_W'(k))
                  hit = 1'b1;
         end
         assign line[k] = hit;
      end else begin : g_dead
         assign line[k] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SRC-1:0]   src_in,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [N_LINES-1:0] irq_line
);
   localparam int N_WORDS = N_SRC * FIELD_W / DATA_W;

   if ((N_SRC * FIELD_W) % DATA_W != 0) begin : g_bad_pack
      $error("source fields must fill whole control words");
   end
   if (N_SRC > DATA_W) begin : g_bad_width
      $error("status word cannot hold all sources");
   end

   logic [N_SRC*FIELD_W-1:0] ctrl_w;
   logic [N_SRC-1:0]         pend_w;
   logic                     clr_hit;

   assign clr_hit = bus_wr && bus_addr == ADDR_W'(A_CLEAR);

   irq_ctrl_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .ctrl_flat(ctrl_w)
   );

   irq_pend_bank #(.N_SRC(N_SRC)) pend_i (
      .clk(clk), .rst_n(rst_n), .src(src_in), .clr_we(clr_hit),
      .clr_mask(bus_wdata[N_SRC-1:0]), .pend(pend_w)
   );

   irq_route_or #(.N_SRC(N_SRC)) route_i (
      .pend(pend_w), .ctrl_flat(ctrl_w), .line(irq_line)
   );

   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < N_WORDS; w++)
         if (bus_addr == ADDR_W'(A_CTRL0 + 4 * w))
            bus_rdata = ctrl_w[w*DATA_W +: DATA_W];
      if (bus_addr == ADDR_W'(A_STATUS))
         bus_rdata = DATA_W'(pend_w);
   end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_SRC-1:0]           src_in,
   input logic                       bus_wr,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic [N_SRC-1:0]           pend_q,
   input logic [N_SRC*FIELD_W-1:0]   ctrl_flat,
   input logic [N_LINES-1:0]         irq_line
);
   logic clr_w;
   assign clr_w = bus_wr && bus_addr == ADDR_W'(A_CLEAR);

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(src_in)) == $past(src_in)));

   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_w |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   // R5 and R6: cleared positions end up equal to the source level
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> ((pend_q & $past(bus_wdata[N_SRC-1:0]))
                 == ($past(src_in) & $past(bus_wdata[N_SRC-1:0]))));

   p_line_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_line) |-> (|pend_q));

   p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(ctrl_flat));
endmodule

bind irq_router_top irq_router_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_w),
   .ctrl_flat(ctrl_w), .irq_line(irq_line)
);

// File: tb/irq_router_top_tb.sv
module irq_router_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  irq_line;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   irq_router_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_line(irq_line)
   );

   // entry: {source[4:0], route[2:0], enable, expected lines[7:0]}
   localparam int NV = 10;
   localparam logic [16:0] VEC [NV] = '{
      {5'd0,  3'd0, 1'b1, 8'h01},
      {5'd9,  3'd1, 1'b1, 8'h02},
      {5'd18, 3'd2, 1'b1, 8'h04},
      {5'd27, 3'd3, 1'b1, 8'h08},
      {5'd31, 3'd4, 1'b1, 8'h10},
      {5'd12, 3'd6, 1'b1, 8'h40},
      {5'd5,  3'd5, 1'b1, 8'h00},
      {5'd22, 3'd7, 1'b1, 8'h00},
      {5'd7,  3'd2, 1'b0, 8'h00},
      {5'd16, 3'd6, 1'b0, 8'h00}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      total++; bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 lines", {24'b0, irq_line}, 32'h0);
      rd(8'h10, d); check("R1 status", d, 32'h0);
      for (int w = 0; w < 4; w++) begin
         rd(8'(4 * w), d); check("R1 ctrl", d, 32'h0);
      end
      rst_n = 1'b1;

      // table walk: R3 R4 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         logic [4:0] s; logic [2:0] r; logic e; logic [7:0] x;
         {s, r, e, x} = VEC[i];
         wr(8'(4 * (s / 8)), 32'({e, r}) << ((s % 8) * 4));
         @(negedge clk); src_in[s] = 1'b1;
         @(negedge clk); src_in[s] = 1'b0;
         @(negedge clk);
         rd(8'h10, d); check("R3 R4 status", d, 32'h1 << s);
         check("R7 R8 R9 lines", {24'b0, irq_line}, {24'b0, x});
         wr(8'h14, 32'h1 << s);
         rd(8'h10, d); check("R5 cleared", d, 32'h0);
         check("R7 lines off", {24'b0, irq_line}, 32'h0);
         wr(8'(4 * (s / 8)), 32'h0);
      end

      // R2 word isolation and field position
      wr(8'h04, 32'hA5A5_1234);
      wr(8'h08, 32'h0000_00E0);
      rd(8'h04, d); check("R2 word1", d, 32'hA5A5_1234);
      rd(8'h08, d); check("R2 word2", d, 32'h0000_00E0);
      rd(8'h00, d); check("R2 word0", d, 32'h0);
      rd(8'h0C, d); check("R2 word3", d, 32'h0);
      // source 17: word2 bits 7:4 = E -> enable, route 6
      @(negedge clk); src_in[17] = 1'b1;
      @(negedge clk); src_in[17] = 1'b0;
      #1 check("R2 R7 src17 line6", {24'b0, irq_line}, 32'h40);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h04, 32'h0); wr(8'h08, 32'h0);

      // R5 partial clear
      @(negedge clk); src_in[1] = 1'b1; src_in[2] = 1'b1;
      @(negedge clk); src_in = '0;
      wr(8'h14, 32'h0000_0002);
      rd(8'h10, d); check("R5 zero bits kept", d, 32'h4);
      rd(8'h14, d); check("R5 clear reads zero", d, 32'h0);
      wr(8'h14, 32'h4);

      // R6 set beats clear
      @(negedge clk); src_in[3] = 1'b1;
      wr(8'h14, 32'h8);
      rd(8'h10, d); check("R6 set wins", d, 32'h8);
      src_in[3] = 1'b0;
      wr(8'h14, 32'h8);
      rd(8'h10, d); check("R6 then cleared", d, 32'h0);

      // R10 status write ignored, unmapped reads zero
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, d); check("R10 status write", d, 32'h0);
      for (int w = 0; w < 4; w++) begin
         rd(8'(4 * w), d); check("R10 ctrl untouched", d, 32'h0);
      end
      wr(8'h18, 32'hDEAD_BEEF);
      rd(8'h18, d); check("R10 unmapped", d, 32'h0);
      rd(8'hFC, d); check("R10 unmapped high", d, 32'h0);

      finish_run();
   end
endmodule